// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Divider

This block turns a reference clock into the timing strobes a real-time clock needs. A short prescaler first brings any of three supported reference frequencies down to a common 32.768 kHz base tick. A 15-stage binary chain then counts those base ticks. The chain supplies a once-per-second update strobe for the timekeeping core and a set of power-of-two taps. One tap, selected by a 4-bit rate code, drives a periodic pulse and a square-wave pin.

The block is driven by control fields held elsewhere. A 3-bit divider-control code picks the reference frequency or holds the whole chain cleared. The rate code picks the periodic tap. Two enables gate the periodic interrupt request and the square-wave pin. The periodic pulse is produced whether or not the interrupt is enabled, so a flag register outside this block can always record it. All outputs are registered. The block is clocked by the reference clock itself. Its asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `rtc_pi_divider`

## Requirements
- R1: While `rst_n` is low, all four outputs are low.
- R2: Divider-control codes 3 to 7 hold the prescaler and chain cleared, with every output low. When a running code (0, 1 or 2) is applied again, counting restarts from zero.
- R3: Divider-control code 0 produces one base tick per 128 reference cycles, code 1 one per 32, and code 2 one per reference cycle.
- R4: For rate code N from 1 to 15, `per_tick` is a one-cycle pulse on every 2^(N-1)-th base tick counted from the restart. The first pulse falls on base tick 2^(N-1).
- R5: With rate code 0, `per_tick` and `sqw_out` stay low.
- R6: `per_irq` pulses together with `per_tick` only while `per_irq_en` is high. `per_tick` does not depend on `per_irq_en`.
- R7: With `sqw_en` high and N from 2 to 15, `sqw_out` has a period of 2^(N-1) base ticks at 50% duty. It is low for the first half of each period, counted from the restart. For N = 1, `sqw_out` alternates every base tick.
- R8: With `sqw_en` low, `sqw_out` is low.
- R9: `upd_1hz` pulses for one cycle on base tick 16384 after a restart and then on every 32768th base tick after that.
- R10: Changing the rate code while the chain runs takes effect at once on the running chain, without restarting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all registers use it |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_ctl | input | 3 | Divider control: 0, 1, 2 select the reference; 3 to 7 hold the chain |
| rate_code | input | 4 | Periodic tap select; 0 turns the periodic output off |
| per_irq_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pin enable |
| per_tick | output | 1 | One-cycle periodic pulse, for the periodic flag |
| per_irq | output | 1 | Periodic interrupt request pulse |
| sqw_out | output | 1 | Square-wave output |
| upd_1hz | output | 1 | One-cycle update strobe, once per second |

## Verification
A wrong count in the prescaler or the chain would shift the phase of every tap. It shows first on the square-wave pin, whose level exposes a chain bit on every cycle. It then shows as a misplaced periodic pulse within one tap period. A chain that fails to clear on hold or restart moves the first update strobe away from base tick 16384, and a free-running reference model detects that at the exact cycle. A gating fault shows as a lone `per_irq` without `per_tick`, or as pin activity at rate 0.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;

  typedef enum logic [1:0] {
    MODE_REF_HI  = 2'd0,
    MODE_REF_MID = 2'd1,
    MODE_REF_LO  = 2'd2,
    MODE_HOLD    = 2'd3
  } rtcdiv_mode_e;

  // Control code to operating mode; every unlisted code holds the chain.
  function automatic rtcdiv_mode_e rtcdiv_decode(input int unsigned code);
    case (code)
      0:       return MODE_REF_HI;
      1:       return MODE_REF_MID;
      2:       return MODE_REF_LO;
      default: return MODE_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/rtcdiv_rst_sync.sv
module rtcdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtcdiv_prescale.sv
module rtcdiv_prescale
  import rtcdiv_pkg::*;
#(
  parameter int DIV_HI  = 128,
  parameter int DIV_MID = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rtcdiv_mode_e mode,
  output logic         base_tick
);
  localparam int LIM_W = $clog2(DIV_HI) + 1;

  logic [LIM_W-1:0] pre_q;
  logic [LIM_W-1:0] pre_d;
  logic [LIM_W-1:0] last;
  logic             run;

  always_comb begin
    case (mode)
      MODE_REF_HI:  last = LIM_W'(DIV_HI - 1);
      MODE_REF_MID: last = LIM_W'(DIV_MID - 1);
      default:      last = '0;
    endcase
    run       = (mode != MODE_HOLD);
    base_tick = run && (pre_q >= last);
    if (!run || base_tick) pre_d = '0;
    else                   pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/rtcdiv_chain.sv
module rtcdiv_chain #(
  parameter int CHAIN_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               base_tick,
  output logic [CHAIN_W-1:0] count
);
  logic [CHAIN_W-1:0] cnt_q;
  logic [CHAIN_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = !run || base_tick;
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rtc_pi_divider.sv
module rtc_pi_divider
  import rtcdiv_pkg::*;
#(
  parameter int CTL_W   = 3,
  parameter int RATE_W  = 4,
  parameter int CHAIN_W = 15,
  parameter int DIV_HI  = 128,
  parameter int DIV_MID = 32
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  div_ctl,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              per_irq_en,
  input  logic              sqw_en,
  output logic              per_tick,
  output logic              per_irq,
  output logic              sqw_out,
  output logic              upd_1hz
);
  localparam int IDX_W = $clog2(CHAIN_W);
  localparam logic [CHAIN_W-1:0] UPD_AT = CHAIN_W'((1 << (CHAIN_W - 1)) - 1);

  logic               srst_n;
  rtcdiv_mode_e       mode;
  logic               run;
  logic               base_tick;
  logic [CHAIN_W-1:0] count;
  logic [CHAIN_W-1:0] tap_mask;
  logic [IDX_W-1:0]   sqw_idx;
  int unsigned        rate_n;
  logic               tick_d, irq_d, sqw_d, upd_d;
  logic               tick_q, irq_q, sqw_q, upd_q;

  rtcdiv_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk_ref), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign mode = rtcdiv_decode(32'(div_ctl));
  assign run  = (mode != MODE_HOLD);

  rtcdiv_prescale #(.DIV_HI(DIV_HI), .DIV_MID(DIV_MID)) i_prescale (
    .clk(clk_ref), .rst_n(srst_n), .mode(mode), .base_tick(base_tick)
  );

  rtcdiv_chain #(.CHAIN_W(CHAIN_W)) i_chain (
    .clk(clk_ref), .rst_n(srst_n), .run(run), .base_tick(base_tick), .count(count)
  );

  // Tap selection: periodic match mask and square-wave bit index.
  always_comb begin
    rate_n   = 32'(rate_code);
    tap_mask = '0;
    sqw_idx  = '0;
    if (rate_n != 0) begin
      tap_mask = CHAIN_W'((1 << (rate_n - 1)) - 1);
      if (rate_n >= 2) sqw_idx = IDX_W'(rate_n - 2);
    end
  end

  always_comb begin
    tick_d = run && base_tick && (rate_n != 0) && ((count & tap_mask) == tap_mask);
    irq_d  = tick_d && per_irq_en;
    upd_d  = run && base_tick && (count == UPD_AT);
    sqw_d  = run && sqw_en && (rate_n != 0) && count[sqw_idx];
  end

  always_ff @(posedge clk_ref or negedge srst_n) begin
    if (!srst_n) begin
      tick_q <= 1'b0;
      irq_q  <= 1'b0;
      sqw_q  <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      irq_q  <= irq_d;
      sqw_q  <= sqw_d;
      upd_q  <= upd_d;
    end
  end

  assign per_tick = tick_q;
  assign per_irq  = irq_q;
  assign sqw_out  = sqw_q;
  assign upd_1hz  = upd_q;
endmodule

// File: rtl/rtc_pi_divider_chk.sv
module rtc_pi_divider_chk #(
  parameter int CTL_W  = 3,
  parameter int RATE_W = 4
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic [CTL_W-1:0]  div_ctl,
  input logic [RATE_W-1:0] rate_code,
  input logic              per_irq_en,
  input logic              sqw_en,
  input logic              per_tick,
  input logic              per_irq,
  input logic              sqw_out,
  input logic              upd_1hz
);
  AST_RESET_QUIET: assert property (@(posedge clk_ref)
    !rst_n |-> !per_tick && !per_irq && !sqw_out && !upd_1hz); // R1

  AST_HOLD_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(div_ctl) > 2) |-> !per_tick && !per_irq && !sqw_out && !upd_1hz); // R2

  AST_RATE0_NO_TICK: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(rate_code) == 0) |-> !per_tick && !sqw_out); // R5

  AST_IRQ_GATED: assert property (@(posedge clk_ref) disable iff (!rst_n)
    per_irq |-> per_tick && $past(per_irq_en)); // R6

  AST_SQW_DISABLED: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$past(sqw_en) |-> !sqw_out); // R8

  AST_UPD_SINGLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    upd_1hz |=> !upd_1hz); // R9
endmodule

bind rtc_pi_divider rtc_pi_divider_chk #(.CTL_W(CTL_W), .RATE_W(RATE_W)) i_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .div_ctl(div_ctl), .rate_code(rate_code),
  .per_irq_en(per_irq_en), .sqw_en(sqw_en), .per_tick(per_tick),
  .per_irq(per_irq), .sqw_out(sqw_out), .upd_1hz(upd_1hz)
);

// File: tb/test_rtc_pi_divider.sv
module test_rtc_pi_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] div_ctl = 3'd2;
  logic [3:0] rate_code = 4'd0;
  logic       pie = 1'b0;
  logic       sqwe = 1'b0;
  logic       per_tick, per_irq, sqw_out, upd_1hz;

  int tests = 0;
  int fails = 0;
  int rel = 0;
  int e = 0;
  bit ex_tick = 0, ex_irq = 0, ex_sqw = 0, ex_upd = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  rtc_pi_divider i_rtc_pi_divider (
    .clk_ref(clk), .rst_n(rst_n), .div_ctl(div_ctl), .rate_code(rate_code),
    .per_irq_en(pie), .sqw_en(sqwe), .per_tick(per_tick), .per_irq(per_irq),
    .sqw_out(sqw_out), .upd_1hz(upd_1hz)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural model: e counts running reference edges since restart.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; e = 0;
      ex_tick = 0; ex_irq = 0; ex_sqw = 0; ex_upd = 0;
    end else begin
      if (rel >= 2 && div_ctl <= 3'd2) begin
        int d, t, c, n;
        bit tk;
        e++;
        d = (div_ctl == 0) ? 128 : (div_ctl == 1) ? 32 : 1;
        n = rate_code;
        t = e / d;
        c = ((e - 1) / d) % 32768;
        tk = (e % d) == 0;
        ex_tick = tk && n != 0 && (t % (1 << (n - 1))) == 0;
        ex_upd  = tk && (t % 32768) == 16384;
        ex_sqw  = sqwe && n != 0 && (((c >> ((n >= 2) ? n - 2 : 0)) & 1) == 1);
        ex_irq  = ex_tick && pie;
      end else begin
        e = 0;
        ex_tick = 0; ex_irq = 0; ex_sqw = 0; ex_upd = 0;
      end
      if (rel < 2) rel++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R4", "per_tick", per_tick, ex_tick);
      chk("R6", "per_irq", per_irq, ex_irq);
      chk("R7", "sqw_out", sqw_out, ex_sqw);
      chk("R9", "upd_1hz", upd_1hz, ex_upd);
    end
  end

  task automatic run(input int n, output int nt, output int ni, output int ns, output int nu);
    nt = 0; ni = 0; ns = 0; nu = 0;
    repeat (n) begin
      @(negedge clk);
      nt += per_tick; ni += per_irq; ns += sqw_out; nu += upd_1hz;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int nt, ni, ns, nu;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {per_tick, per_irq, sqw_out, upd_1hz}, 0);

    // Base reference, slowest tap, update strobes.
    rate_code = 4'd15; pie = 1'b1; sqwe = 1'b1;
    rst_n = 1'b1; cmp_on = 1;
    run(50000, nt, ni, ns, nu);
    chk("R9", "update strobes in window", nu, 2);
    chk("R4", "rate 15 pulses", nt, 3);
    chk("R6", "irq pulses while enabled", ni, 3);

    // Hold codes clear everything.
    rate_code = 4'd1;
    for (int k = 3; k <= 7; k++) begin
      div_ctl = 3'(k);
      run(40, nt, ni, ns, nu);
      chk("R2", "hold activity", nt + ni + ns + nu, 0);
    end

    // Highest reference: 128 cycles per base tick, rate 3, irq disabled.
    div_ctl = 3'd0; rate_code = 4'd3; pie = 1'b0;
    run(4096, nt, ni, ns, nu);
    chk("R3", "code 0 pulse count", nt, 8);
    chk("R6", "irq while disabled", ni, 0);
    chk("R7", "rate 3 sqw high cycles", ns, 2048);

    // Middle reference: 32 cycles per base tick, rate 1.
    div_ctl = 3'd7;
    @(negedge clk);
    div_ctl = 3'd1; rate_code = 4'd1; pie = 1'b1;
    run(640, nt, ni, ns, nu);
    chk("R3", "code 1 pulse count", nt, 20);
    chk("R7", "rate 1 sqw high cycles", ns, 320);

    // Rate change on the running chain.
    div_ctl = 3'd5;
    @(negedge clk);
    div_ctl = 3'd2; rate_code = 4'd4;
    run(100, nt, ni, ns, nu);
    chk("R4", "rate 4 pulses", nt, 12);
    rate_code = 4'd2;
    run(64, nt, ni, ns, nu);
    chk("R10", "rate 2 pulses after switch", nt, 32);

    // Rate 0 silences pulse and pin.
    rate_code = 4'd0;
    run(200, nt, ni, ns, nu);
    chk("R5", "rate 0 activity", nt + ns, 0);

    // Square-wave enable low.
    rate_code = 4'd5; sqwe = 1'b0;
    run(200, nt, ni, ns, nu);
    chk("R8", "sqw with enable low", ns, 0);
    chk("R4", "rate 5 pulses still present", (nt > 0) ? 1 : 0, 1);

    cmp_on = 0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after async reset", {per_tick, per_irq, sqw_out, upd_1hz}, 0);
    finish_run();
  end
endmodule